// File: doc/BRIEF.md
# Half-Bridge Channel Gate Controller

This block turns the logic-level drive request for one half-bridge leg into two separate gate commands, one for the high-side switch and one for the low-side switch. An enable input and a chip-wide disable can both float the leg, leaving both switches off and the output high-impedance. When the leg is enabled, the level input selects which side conducts. Whenever conduction passes from one side to the other, the controller holds both gates off for a fixed dead-time window first, so the two switches can never conduct together.

The block also watches two overcurrent flags, one for each switch, which stand in for the analog current-limit detector. If either flag stays high for the deglitch window, the leg is shut down and a sticky fault bit is set. That fault clears only through the synchronous active-low reset.

Both time constants are given in nanoseconds together with the clock frequency in MHz. They are rounded up to whole clock cycles. With the defaults (50 MHz, 90 ns, 5000 ns) the dead time is 5 cycles and the deglitch window is 250 cycles.

The leg is a four-state machine:
- IDLE: both off, dead time already served.
- DEAD: both off, dead time being counted.
- HIGH: high side on.
- LOW: low side on.

Its transitions are:
- IDLE to HIGH or LOW on a matching request.
- HIGH or LOW to DEAD when the request changes.
- DEAD to HIGH, LOW or IDLE, following the request in force when the window ends.

The overcurrent guard has three states:
- CLEAR to TIMING on the first flagged cycle.
- TIMING back to CLEAR when the flags drop.
- TIMING to LATCHED on the last cycle of the window.
- LATCHED is left only through reset.

Top module: `hb_gate_ctrl`

## Requirements
- R1: With `en` low, both gates are low from the first clock edge that samples it, whatever `in_lvl` is.
- R2: With `en` high, `disable_all` low and no fault, `in_lvl` high requests the high-side gate and `in_lvl` low requests the low-side gate. From IDLE, the requested gate rises on the first edge that samples the request.
- R3: When the request moves from one side to the other, both gates are low for exactly DEAD_CYC consecutive cycles before the new side turns on. DEAD_CYC is ceil(DEAD_NS*CLK_MHZ/1000), which is 5 by default.
- R4: `gate_hi` and `gate_lo` are never high in the same cycle.
- R5: The new side also waits out the full dead time when the request returns to the side that was just turned off.
- R6: If `oc_hs` or `oc_ls` (either one) is sampled high for TRIP_CYC consecutive edges, `fault` rises and both gates drop on that same edge. TRIP_CYC is ceil(TRIP_NS*CLK_MHZ/1000), which is 250 by default.
- R7: A run of fewer than TRIP_CYC flagged edges sets no fault, and the next run starts counting again from zero.
- R8: Once `fault` is set, it stays high and both gates stay low whatever `in_lvl`, `en`, `disable_all` and the flags do, until reset.
- R9: `rst_n` low, sampled at an edge, clears `fault` and turns both gates off from that edge. Inputs are ignored while it is low.
- R10: `disable_all` high forces both gates low exactly as `en` low does.
- R11: `hiz` is high exactly when both gates are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; clears the fault |
| in_lvl | input | 1 | Requested output level (1 = high side, 0 = low side) |
| en | input | 1 | Leg enable; low floats the output |
| disable_all | input | 1 | Chip-wide disable; high floats the output |
| oc_hs | input | 1 | Overcurrent flag of the high-side switch |
| oc_ls | input | 1 | Overcurrent flag of the low-side switch |
| gate_hi | output | 1 | High-side gate command |
| gate_lo | output | 1 | Low-side gate command |
| hiz | output | 1 | Both gates off (output floating) |
| fault | output | 1 | Latched overcurrent shutdown |

## Verification
A wrong leg state, such as a lost dead-time count or a missed return to IDLE, shows on the gate pins within one cycle. Examples are a gate that rises a cycle early or late, or both gates high together. Comparing the gates on every clock against a reference that only tracks the side driven and the remaining gap therefore exposes it at once. A wrong deglitch count shows only at the end of a flagged run, as `fault` rising one edge early or late. The bench therefore drives runs of exactly TRIP_CYC-1 and TRIP_CYC edges and checks the edge on which the fault appears.

// File: rtl/hbg_pkg.sv
package hbg_pkg;

    typedef enum logic [1:0] {
        LEG_IDLE,
        LEG_DEAD,
        LEG_HIGH,
        LEG_LOW
    } leg_state_t;

    typedef enum logic [1:0] {
        OC_CLEAR,
        OC_TIMING,
        OC_LATCHED
    } oc_state_t;

    typedef enum logic [1:0] {
        REQ_NONE,
        REQ_HIGH,
        REQ_LOW
    } leg_req_t;

    // Rounded-up conversion of a duration to clock cycles, never below one.
    function automatic int ns_to_cycles(input int ns, input int clk_mhz);
        int c;
        c = (ns * clk_mhz + 999) / 1000;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/hbg_ocp_guard.sv
module hbg_ocp_guard
    import hbg_pkg::*;
#(
    parameter int TRIP_CYC = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic oc_any,
    output logic kill,
    output logic fault
);
    localparam int CW = $clog2(TRIP_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(TRIP_CYC - 1);

    oc_state_t     state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          trip_now;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= OC_CLEAR;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        trip_now = 1'b0;
        unique case (state_q)
            OC_CLEAR: begin
                if (oc_any) begin
                    if (TRIP_CYC == 1) begin
                        trip_now = 1'b1;
                        state_d  = OC_LATCHED;
                    end else begin
                        state_d = OC_TIMING;
                        cnt_d   = CW'(1);
                    end
                end
            end
            OC_TIMING: begin
                if (!oc_any) begin
                    state_d = OC_CLEAR;
                    cnt_d   = '0;
                end else if (cnt_q == LAST) begin
                    trip_now = 1'b1;
                    state_d  = OC_LATCHED;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            OC_LATCHED: begin
                state_d = OC_LATCHED;
            end
            default: begin
                state_d = OC_CLEAR;
                cnt_d   = '0;
            end
        endcase
    end

    always_comb begin
        fault = (state_q == OC_LATCHED);
        kill  = fault | trip_now;
    end

endmodule

// File: rtl/hbg_leg_fsm.sv
module hbg_leg_fsm
    import hbg_pkg::*;
#(
    parameter int DEAD_CYC = 5
) (
    input  logic     clk,
    input  logic     rst_n,
    input  leg_req_t req,
    output logic     gate_hi,
    output logic     gate_lo
);
    localparam int DW = $clog2(DEAD_CYC + 1);
    localparam logic [DW-1:0] LAST = DW'(DEAD_CYC - 1);

    leg_state_t    state_q, state_d;
    logic [DW-1:0] gap_q, gap_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LEG_IDLE;
            gap_q   <= '0;
        end else begin
            state_q <= state_d;
            gap_q   <= gap_d;
        end
    end

    always_comb begin
        state_d = state_q;
        gap_d   = gap_q;
        unique case (state_q)
            LEG_IDLE: begin
                if (req == REQ_HIGH)     state_d = LEG_HIGH;
                else if (req == REQ_LOW) state_d = LEG_LOW;
            end
            LEG_HIGH: begin
                if (req != REQ_HIGH) begin
                    state_d = LEG_DEAD;
                    gap_d   = '0;
                end
            end
            LEG_LOW: begin
                if (req != REQ_LOW) begin
                    state_d = LEG_DEAD;
                    gap_d   = '0;
                end
            end
            LEG_DEAD: begin
                if (gap_q == LAST) begin
                    gap_d = '0;
                    if (req == REQ_HIGH)     state_d = LEG_HIGH;
                    else if (req == REQ_LOW) state_d = LEG_LOW;
                    else                     state_d = LEG_IDLE;
                end else begin
                    gap_d = gap_q + 1'b1;
                end
            end
            default: begin
                state_d = LEG_IDLE;
                gap_d   = '0;
            end
        endcase
    end

    always_comb begin
        gate_hi = (state_q == LEG_HIGH);
        gate_lo = (state_q == LEG_LOW);
    end

endmodule

// File: rtl/hb_gate_ctrl.sv
module hb_gate_ctrl
    import hbg_pkg::*;
#(
    parameter int CLK_MHZ = 50,
    parameter int DEAD_NS = 90,
    parameter int TRIP_NS = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_lvl,
    input  logic en,
    input  logic disable_all,
    input  logic oc_hs,
    input  logic oc_ls,
    output logic gate_hi,
    output logic gate_lo,
    output logic hiz,
    output logic fault
);
    localparam int DEAD_CYC = ns_to_cycles(DEAD_NS, CLK_MHZ);
    localparam int TRIP_CYC = ns_to_cycles(TRIP_NS, CLK_MHZ);

    logic     kill;
    leg_req_t req;

    hbg_ocp_guard #(.TRIP_CYC(TRIP_CYC)) u_guard (
        .clk    (clk),
        .rst_n  (rst_n),
        .oc_any (oc_hs | oc_ls),
        .kill   (kill),
        .fault  (fault)
    );

    always_comb begin
        if (kill || !en || disable_all) req = REQ_NONE;
        else if (in_lvl)                req = REQ_HIGH;
        else                            req = REQ_LOW;
    end

    hbg_leg_fsm #(.DEAD_CYC(DEAD_CYC)) u_leg (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req),
        .gate_hi (gate_hi),
        .gate_lo (gate_lo)
    );

    assign hiz = ~(gate_hi | gate_lo);

endmodule

// File: rtl/hbg_checker.sv
module hbg_checker #(
    parameter int DEAD_CYC = 5
) (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic oc_hs,
    input logic oc_ls,
    input logic gate_hi,
    input logic gate_lo,
    input logic fault
);
    int   off_run;
    logic last_hi;
    logic last_lo;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_run <= 0;
            last_hi <= 1'b0;
            last_lo <= 1'b0;
        end else begin
            if (!gate_hi && !gate_lo) off_run <= (off_run < 1000) ? off_run + 1 : off_run;
            else                      off_run <= 0;
            if (gate_hi) begin last_hi <= 1'b1; last_lo <= 1'b0; end
            if (gate_lo) begin last_lo <= 1'b1; last_hi <= 1'b0; end
        end
    end

    a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_hi && gate_lo));

    a_r3_gap_lo: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(gate_lo) && last_hi) |-> off_run >= DEAD_CYC);

    a_r3_gap_hi: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(gate_hi) && last_lo) |-> off_run >= DEAD_CYC);

    a_r1_en_low_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!gate_hi && !gate_lo));

    a_r6_fault_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault) |-> $past(oc_hs || oc_ls));

    a_r8_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> fault);

    a_r8_fault_gates_off: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (!gate_hi && !gate_lo));

    a_r9_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!gate_hi && !gate_lo && !fault));

endmodule

bind hb_gate_ctrl hbg_checker #(.DEAD_CYC(DEAD_CYC)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .oc_hs   (oc_hs),
    .oc_ls   (oc_ls),
    .gate_hi (gate_hi),
    .gate_lo (gate_lo),
    .fault   (fault)
);

// File: tb/tb_hb_gate_ctrl.sv
module tb_hb_gate_ctrl;
    localparam int DEAD = 5;    // 90 ns at 50 MHz, rounded up
    localparam int TRIP = 250;  // 5000 ns at 50 MHz

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_lvl = 1'b0, en = 1'b0, disable_all = 1'b0, oc_hs = 1'b0, oc_ls = 1'b0;
    logic gate_hi, gate_lo, hiz, fault;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit cmp_on = 1'b0;

    always #10 clk = ~clk;

    hb_gate_ctrl dut (
        .clk(clk), .rst_n(rst_n), .in_lvl(in_lvl), .en(en),
        .disable_all(disable_all), .oc_hs(oc_hs), .oc_ls(oc_ls),
        .gate_hi(gate_hi), .gate_lo(gate_lo), .hiz(hiz), .fault(fault)
    );

    // Reference: which side conducts (0 none, 1 high, 2 low), cycles of gap left,
    // length of the current overcurrent run, and the latched fault.
    int m_side = 0;
    int m_gap = 0;
    int m_run = 0;
    bit m_flt = 1'b0;

    always @(posedge clk) begin
        int want;
        bit oc;
        bit trip;
        if (!rst_n) begin
            m_side = 0; m_gap = 0; m_run = 0; m_flt = 1'b0;
        end else begin
            oc = oc_hs || oc_ls;
            trip = m_flt || (oc && (m_run + 1 >= TRIP));
            if (!oc) m_run = 0;
            else if (!m_flt) begin
                m_run = m_run + 1;
                if (m_run >= TRIP) m_flt = 1'b1;
            end
            want = (trip || !en || disable_all) ? 0 : (in_lvl ? 1 : 2);
            if (m_gap > 0) begin
                m_gap = m_gap - 1;
                if (m_gap == 0) m_side = want;
            end else if (m_side == 0) begin
                m_side = want;
            end else if (want != m_side) begin
                m_side = 0;
                m_gap = DEAD;
            end
        end
        cmp_on = 1'b1;
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on && !done) begin
            check("R2 model gate_hi", gate_hi, m_side == 1);
            check("R2 model gate_lo", gate_lo, m_side == 2);
            check("R6 model fault", fault, m_flt);
            check("R11 hiz", hiz, !gate_hi && !gate_lo);
            check("R4 no overlap", gate_hi && gate_lo, 0);
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int n;
        // R9 reset state
        step(3);
        check("R9 reset gate_hi", gate_hi, 0);
        check("R9 reset gate_lo", gate_lo, 0);
        check("R9 reset fault", fault, 0);
        check("R11 reset hiz", hiz, 1);
        rst_n = 1'b1;
        step(2);

        // R2 turn-on from idle takes one edge
        en = 1'b1; in_lvl = 1'b1;
        step(1);
        check("R2 high side on", gate_hi, 1);
        check("R11 hiz low", hiz, 0);

        // R3 high to low: exactly DEAD off cycles
        in_lvl = 1'b0;
        n = 0;
        do begin
            step(1);
            if (!gate_hi && !gate_lo) n++;
        end while (!gate_lo && n < 50);
        check("R3 dead cycles hi->lo", n, DEAD);
        check("R2 low side on", gate_lo, 1);

        // R5 request bounce back to low side during the gap
        in_lvl = 1'b1;
        step(1);
        in_lvl = 1'b0;
        n = 1;
        do begin
            step(1);
            if (!gate_hi && !gate_lo) n++;
        end while (!gate_lo && n < 50);
        check("R5 full gap on return", n, DEAD);

        // R1 en low ignores in_lvl
        en = 1'b0;
        step(1);
        check("R1 en low gate_lo", gate_lo, 0);
        in_lvl = 1'b1;
        step(DEAD + 3);
        check("R1 en low gate_hi", gate_hi, 0);
        check("R11 floating", hiz, 1);

        // R10 global disable
        en = 1'b1;
        step(DEAD + 2);
        check("R2 high after enable", gate_hi, 1);
        disable_all = 1'b1;
        step(1);
        check("R10 disable off", gate_hi, 0);
        step(4);
        check("R10 disable stays off", gate_hi | gate_lo, 0);
        disable_all = 1'b0;
        step(DEAD + 2);

        // R7 short runs on either flag set no fault
        oc_hs = 1'b1;
        step(TRIP - 1);
        oc_hs = 1'b0;
        step(1);
        check("R7 short hs run", fault, 0);
        oc_ls = 1'b1;
        step(TRIP - 1);
        oc_ls = 1'b0;
        step(1);
        check("R7 short ls run", fault, 0);
        check("R7 leg still on", gate_hi, 1);

        // R6 full run on low-side flag
        oc_ls = 1'b1;
        step(TRIP - 1);
        check("R6 no fault one edge early", fault, 0);
        check("R6 gate on one edge early", gate_hi, 1);
        step(1);
        check("R6 fault on last edge", fault, 1);
        check("R6 gate off on same edge", gate_hi, 0);
        oc_ls = 1'b0;

        // R8 sticky fault
        for (int i = 0; i < 20; i++) begin
            in_lvl = i[0]; en = i[1]; step(1);
        end
        check("R8 fault held", fault, 1);
        check("R8 gates held off", gate_hi | gate_lo, 0);

        // R9 reset clears fault and ignores inputs
        en = 1'b1; in_lvl = 1'b1; oc_hs = 1'b1;
        rst_n = 1'b0;
        step(3);
        check("R9 fault cleared", fault, 0);
        check("R9 inputs ignored", gate_hi, 0);
        oc_hs = 1'b0;
        rst_n = 1'b1;
        step(1);
        check("R9 resumes after reset", gate_hi, 1);

        // Mixed random traffic compared every clock
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 5) == 0) in_lvl = $urandom_range(0, 1);
            if ($urandom_range(0, 15) == 0) en = $urandom_range(0, 3) != 0;
            if ($urandom_range(0, 40) == 0) disable_all = ~disable_all;
            if ($urandom_range(0, 60) == 0) oc_hs = ~oc_hs;
            if ($urandom_range(0, 400) == 0) oc_ls = ~oc_ls;
            rst_n = ($urandom_range(0, 900) != 0);
            step(1);
        end
        rst_n = 1'b1;
        step(2);
        finish_run();
    end

endmodule